// File: doc/BRIEF.md
# Mixed-Precision Packed Tile Multiply-Accumulate Unit

This unit executes one matrix multiply-accumulate step per issue. It multiplies a small tile of signed 8-bit activations by a tile of signed 4-bit weights and adds the dot products into a tile of 16-bit accumulators. The weights sit back to back in a 128-bit operand with no extension gaps. So one 128-bit word carries 32 weights, and the 16-bit output tile of 8 lanes fills the same 128 bits that four 32-bit accumulators would fill in an equal-width 8×8 design. Each instruction therefore handles twice as many weights and yields twice as many results as that equal-width form.

With the default geometry, A holds 2 rows of 8 activations, B holds 8 rows of 4 weights, and C is a 2×4 tile. The accumulator tile comes in as an operand and goes out as a result. Software can therefore keep one accumulator register stationary across a loop of issues and feed `acc_q_o` back into `acc_i`. A clear flag starts a fresh sum.

Lanes saturate to the 16-bit rails and stay pinned there. Downstream code can detect overflow by looking for the two rail values, or it can simply consume the clamped numbers. A per-lane flag also reports the overflow in the cycle the result appears.

Top module: `mpmac_tile`

## Requirements
- R1: Activation A[i][j] (row i in 0..1, column j in 0..7) is the signed two's-complement byte at bits (i*8+j)*8 of `act_i`.
- R2: Weight B[k][c] (row k in 0..7, column c in 0..3) is the signed two's-complement nibble at bits (k*4+c)*4 of `wgt_i`, least significant nibble first, with no gaps.
- R3: On an issue, lane l = i*4+c occupies bits l*16 of `acc_q_o`. Its new value is the incoming lane of `acc_i` plus the sum over j of A[i][j]*B[j][c], provided the true sum lies in [-32768, 32767].
- R4: When `clr_i` is high with an issue, every incoming accumulator lane is treated as zero, including lanes at a rail value. With the default geometry no lane can then overflow.
- R5: A true sum above 32767 yields 32767 and a sum below -32768 yields -32768. In either case that lane's bit of `ovf_o` is 1. A lane whose sum is in range has its `ovf_o` bit at 0.
- R6: With `clr_i` low, an incoming lane equal to 32767 or -32768 is passed through unchanged whatever the dot product is, and its `ovf_o` bit is set.
- R7: `vld_o` is 1 exactly in the cycle after a cycle with `issue_i` high. `acc_q_o` and `ovf_o` take their new values on that same clock edge.
- R8: Without an issue, `acc_q_o` and `ovf_o` keep their values whatever `act_i`, `wgt_i`, `acc_i` and `clr_i` do.
- R9: While `rst_ni` is low, `acc_q_o`, `ovf_o` and `vld_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue qualifier for one multiply-accumulate step |
| clr_i | input | 1 | Treat incoming accumulators as zero for this issue |
| act_i | input | 128 | Packed 2×8 signed 8-bit activation tile |
| wgt_i | input | 128 | Packed 8×4 signed 4-bit weight tile |
| acc_i | input | 128 | Incoming 2×4 tile of signed 16-bit accumulators |
| acc_q_o | output | 128 | Registered result tile of signed 16-bit lanes |
| ovf_o | output | 8 | Per-lane saturation flag for the last issue |
| vld_o | output | 1 | Result of the previous cycle's issue is present |

## Verification
All three outputs depend on only one register stage. A result, its overflow flags and `vld_o` are therefore due on the first rising edge after the issue cycle, and they must then hold until the next issue. The bench drives each issue just after a falling edge and updates a behavioural model to the state it expects after the next rising edge. It compares every output lane with that model one falling edge later. Idle cycles, saturation, pinned rails and the clear flag therefore all meet the same one-cycle schedule.

// File: rtl/mpmac_pkg.sv
package mpmac_pkg;

    // Default tile geometry and element widths.
    localparam int unsigned DEF_ACT_W = 8;
    localparam int unsigned DEF_WGT_W = 4;
    localparam int unsigned DEF_ACC_W = 16;
    localparam int unsigned DEF_ROWS  = 2;
    localparam int unsigned DEF_DEPTH = 8;
    localparam int unsigned DEF_COLS  = 4;

    // Width needed to hold a full dot product without loss.
    function automatic int unsigned dot_width(input int unsigned act_w,
                                              input int unsigned wgt_w,
                                              input int unsigned depth);
        return act_w + wgt_w + $clog2(depth);
    endfunction

endpackage

// File: rtl/mpmac_dot.sv
// One lane's signed dot product, kept at full precision.
module mpmac_dot #(
    parameter int unsigned ACT_W = 8,
    parameter int unsigned WGT_W = 4,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned SUM_W = 15
) (
    input  logic [DEPTH*ACT_W-1:0]    act_row_i,
    input  logic [DEPTH*WGT_W-1:0]    wgt_col_i,
    output logic signed [SUM_W-1:0]   dot_o
);

    localparam int unsigned PROD_W = ACT_W + WGT_W;

    logic signed [PROD_W-1:0] prod [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_mul
        logic signed [ACT_W-1:0] a_el;
        logic signed [WGT_W-1:0] w_el;
        assign a_el = act_row_i[j*ACT_W +: ACT_W];
        assign w_el = wgt_col_i[j*WGT_W +: WGT_W];
        assign prod[j] = PROD_W'(a_el) * PROD_W'(w_el);
    end

    always_comb begin
        dot_o = '0;
        for (int j = 0; j < DEPTH; j++) begin
            dot_o = dot_o + SUM_W'(prod[j]);
        end
    end

endmodule

// File: rtl/mpmac_satacc.sv
// Saturating add of one dot product into one accumulator lane, with rail pinning.
module mpmac_satacc #(
    parameter int unsigned ACC_W = 16,
    parameter int unsigned SUM_W = 15
) (
    input  logic                    clr_i,
    input  logic [ACC_W-1:0]        acc_i,
    input  logic signed [SUM_W-1:0] dot_i,
    output logic [ACC_W-1:0]        acc_o,
    output logic                    ovf_o
);

    localparam int unsigned WIDE_W = ((SUM_W > ACC_W) ? SUM_W : ACC_W) + 1;
    localparam logic [ACC_W-1:0] RAIL_HI = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] RAIL_LO = {1'b1, {(ACC_W-1){1'b0}}};
    localparam int unsigned TOP_N = WIDE_W - ACC_W + 1;

    logic [ACC_W-1:0]  base;
    logic              pinned;
    logic [WIDE_W-1:0] wide;
    logic [TOP_N-1:0]  top_bits;
    logic              out_of_range;

    always_comb begin
        base         = clr_i ? '0 : acc_i;
        pinned       = !clr_i && ((acc_i == RAIL_HI) || (acc_i == RAIL_LO));
        wide         = WIDE_W'(signed'(base)) + WIDE_W'(dot_i);
        top_bits     = wide[WIDE_W-1:ACC_W-1];
        out_of_range = !((top_bits == '0) || (top_bits == '1));

        if (pinned) begin
            acc_o = acc_i;
            ovf_o = 1'b1;
        end else if (out_of_range) begin
            acc_o = wide[WIDE_W-1] ? RAIL_LO : RAIL_HI;
            ovf_o = 1'b1;
        end else begin
            acc_o = wide[ACC_W-1:0];
            ovf_o = 1'b0;
        end
    end

endmodule

// File: rtl/mpmac_tile.sv
module mpmac_tile
    import mpmac_pkg::*;
#(
    parameter int unsigned ACT_W = DEF_ACT_W,
    parameter int unsigned WGT_W = DEF_WGT_W,
    parameter int unsigned ACC_W = DEF_ACC_W,
    parameter int unsigned ROWS  = DEF_ROWS,
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned COLS  = DEF_COLS,
    localparam int unsigned LANES = ROWS * COLS,
    localparam int unsigned A_W   = ROWS * DEPTH * ACT_W,
    localparam int unsigned B_W   = DEPTH * COLS * WGT_W,
    localparam int unsigned C_W   = LANES * ACC_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             issue_i,
    input  logic             clr_i,
    input  logic [A_W-1:0]   act_i,
    input  logic [B_W-1:0]   wgt_i,
    input  logic [C_W-1:0]   acc_i,
    output logic [C_W-1:0]   acc_q_o,
    output logic [LANES-1:0] ovf_o,
    output logic             vld_o
);

    localparam int unsigned SUM_W = dot_width(ACT_W, WGT_W, DEPTH);
    localparam logic [ACC_W-1:0] RAIL_HI = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] RAIL_LO = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic             vld;
        logic [LANES-1:0] ovf;
        logic [C_W-1:0]   acc;
    } tile_state_t;

    tile_state_t st_d, st_q;

    logic [C_W-1:0]   lane_acc;
    logic [LANES-1:0] lane_ovf;

    // Per-lane datapath: gather the weight column, form the dot product, saturate.
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int unsigned L = i * COLS + c;
            logic [DEPTH*WGT_W-1:0] wcol;
            logic signed [SUM_W-1:0] dot;

            for (genvar k = 0; k < DEPTH; k++) begin : g_gather
                assign wcol[k*WGT_W +: WGT_W] = wgt_i[(k*COLS + c)*WGT_W +: WGT_W];
            end

            mpmac_dot #(
                .ACT_W (ACT_W),
                .WGT_W (WGT_W),
                .DEPTH (DEPTH),
                .SUM_W (SUM_W)
            ) u_dot (
                .act_row_i (act_i[i*DEPTH*ACT_W +: DEPTH*ACT_W]),
                .wgt_col_i (wcol),
                .dot_o     (dot)
            );

            mpmac_satacc #(
                .ACC_W (ACC_W),
                .SUM_W (SUM_W)
            ) u_sat (
                .clr_i (clr_i),
                .acc_i (acc_i[L*ACC_W +: ACC_W]),
                .dot_i (dot),
                .acc_o (lane_acc[L*ACC_W +: ACC_W]),
                .ovf_o (lane_ovf[L])
            );
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = issue_i;
        if (issue_i) begin
            st_d.acc = lane_acc;
            st_d.ovf = lane_ovf;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q_o = st_q.acc;
    assign ovf_o   = st_q.ovf;
    assign vld_o   = st_q.vld;

    AST_ISSUE_TO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i |=> vld_o); // R7
    AST_IDLE_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_i |=> !vld_o); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_i |=> ($stable(acc_q_o) && $stable(ovf_o))); // R8

    if (SUM_W <= ACC_W) begin : g_clr_chk
        AST_CLEAR_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (issue_i && clr_i) |=> (ovf_o == '0)); // R4
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        AST_PIN_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (issue_i && !clr_i && acc_i[l*ACC_W +: ACC_W] == RAIL_HI)
            |=> (acc_q_o[l*ACC_W +: ACC_W] == RAIL_HI && ovf_o[l])); // R6
        AST_PIN_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (issue_i && !clr_i && acc_i[l*ACC_W +: ACC_W] == RAIL_LO)
            |=> (acc_q_o[l*ACC_W +: ACC_W] == RAIL_LO && ovf_o[l])); // R6
        AST_OVF_ON_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ovf_o[l] |-> (acc_q_o[l*ACC_W +: ACC_W] == RAIL_HI ||
                          acc_q_o[l*ACC_W +: ACC_W] == RAIL_LO)); // R5
    end

endmodule

// File: tb/sim_mpmac_tile.sv
module sim_mpmac_tile;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue = 1'b0;
    logic         clr = 1'b0;
    logic [127:0] act = '0;
    logic [127:0] wgt = '0;
    logic [127:0] acc_in = '0;
    logic [127:0] acc_out;
    logic [7:0]   ovf;
    logic         vld;

    always #10 clk = ~clk;

    mpmac_tile u0 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .issue_i (issue),
        .clr_i   (clr),
        .act_i   (act),
        .wgt_i   (wgt),
        .acc_i   (acc_in),
        .acc_q_o (acc_out),
        .ovf_o   (ovf),
        .vld_o   (vld)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R9";
    int    e_acc [8];
    bit    e_ovf [8];
    bit    e_vld = 1'b0;
    bit    done = 1'b0;

    function automatic int lane_of(input logic [127:0] v, input int l);
        logic signed [15:0] x;
        x = v[l*16 +: 16];
        return int'(x);
    endfunction

    function automatic logic [127:0] fill8(input int v);
        logic [127:0] r;
        for (int n = 0; n < 16; n++) r[n*8 +: 8] = 8'(v);
        return r;
    endfunction

    function automatic logic [127:0] fill4(input int v);
        logic [127:0] r;
        for (int n = 0; n < 32; n++) r[n*4 +: 4] = 4'(v);
        return r;
    endfunction

    function automatic logic [127:0] fill16(input int v);
        logic [127:0] r;
        for (int n = 0; n < 8; n++) r[n*16 +: 16] = 16'(v);
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check_int(input string t, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, got, exp);
        end
    endtask

    task automatic compare_all();
        check_int(tag, "vld", int'(vld), int'(e_vld));
        for (int l = 0; l < 8; l++) begin
            check_int(tag, $sformatf("lane%0d value", l), lane_of(acc_out, l), e_acc[l]);
            check_int(tag, $sformatf("lane%0d ovf", l), int'(ovf[l]), int'(e_ovf[l]));
        end
    endtask

    // Behavioural expectation for the state after the next rising edge.
    task automatic model_next();
        if (!rst_n) begin
            for (int l = 0; l < 8; l++) begin e_acc[l] = 0; e_ovf[l] = 0; end
            e_vld = 0;
            return;
        end
        e_vld = issue;
        if (!issue) return;
        for (int i = 0; i < 2; i++) begin
            for (int c = 0; c < 4; c++) begin
                int l, dot, base, s;
                logic signed [7:0] a;
                logic signed [3:0] b;
                l = i*4 + c;
                dot = 0;
                for (int j = 0; j < 8; j++) begin
                    a = act[(i*8 + j)*8 +: 8];
                    b = wgt[(j*4 + c)*4 +: 4];
                    dot += int'(a) * int'(b);
                end
                base = clr ? 0 : lane_of(acc_in, l);
                if (!clr && (base == 32767 || base == -32768)) begin
                    e_acc[l] = base; e_ovf[l] = 1;
                end else begin
                    s = base + dot;
                    if (s > 32767) begin e_acc[l] = 32767; e_ovf[l] = 1; end
                    else if (s < -32768) begin e_acc[l] = -32768; e_ovf[l] = 1; end
                    else begin e_acc[l] = s; e_ovf[l] = 0; end
                end
            end
        end
    endtask

    task automatic cyc(input bit rn, input bit is, input bit cl,
                       input logic [127:0] a, input logic [127:0] b, input logic [127:0] ci);
        @(negedge clk);
        compare_all();
        rst_n = rn; issue = is; clr = cl; act = a; wgt = b; acc_in = ci;
        model_next();
    endtask

    initial begin
        logic [127:0] a, b;
        for (int l = 0; l < 8; l++) begin e_acc[l] = 0; e_ovf[l] = 0; end
        // R9: reset state, with issues attempted during reset
        tag = "R9";
        cyc(0, 0, 0, '0, '0, '0);
        cyc(0, 1, 0, fill8(3), fill4(2), fill16(5));
        cyc(0, 1, 1, rnd128(), rnd128(), rnd128());
        // R1 / R2: single-element placement
        tag = "R2";
        a = '0; b = '0;
        a[(0*8 + 3)*8 +: 8] = 8'sd5;
        b[(3*4 + 2)*4 +: 4] = -4'sd3;
        a[(1*8 + 6)*8 +: 8] = -8'sd7;
        b[(6*4 + 0)*4 +: 4] = 4'sd2;
        cyc(1, 1, 1, a, b, rnd128());
        cyc(1, 0, 0, '0, '0, '0);
        check_int("R2", "lane2 direct", lane_of(acc_out, 2), -15);
        tag = "R1";
        check_int("R1", "lane4 direct", lane_of(acc_out, 4), -14);
        // R3 with accumulate: random operands, feed output back
        tag = "R3";
        cyc(1, 1, 0, rnd128(), rnd128(), fill16(1000));
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            compare_all();
            issue = 1; clr = 0; act = rnd128(); wgt = rnd128(); acc_in = acc_out;
            model_next();
        end
        // R4: clear, including rail inputs
        tag = "R4";
        cyc(1, 1, 1, rnd128(), rnd128(), fill16(32767));
        cyc(1, 1, 1, fill8(-128), fill4(-8), fill16(-32768));
        cyc(1, 0, 0, '0, '0, '0);
        check_int("R4", "lane0 max dot", lane_of(acc_out, 0), 8192);
        // R5: saturation both directions
        tag = "R5";
        cyc(1, 1, 0, fill8(127), fill4(7), fill16(32000));
        cyc(1, 1, 0, fill8(127), fill4(-8), fill16(-32000));
        cyc(1, 1, 0, fill8(1), fill4(1), fill16(32758));
        cyc(1, 1, 0, fill8(-1), fill4(1), fill16(-32759));
        cyc(1, 0, 0, '0, '0, '0);
        check_int("R5", "lane3 edge", lane_of(acc_out, 3), -32767);
        // R6: pinned rails survive opposite-sign dot products
        tag = "R6";
        cyc(1, 1, 0, fill8(127), fill4(-8), fill16(32767));
        cyc(1, 1, 0, fill8(127), fill4(7), fill16(-32768));
        cyc(1, 1, 0, rnd128(), rnd128(), {fill16(32767)} ^ {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
        // R7 / R8: idle gaps with changing inputs
        tag = "R8";
        cyc(1, 1, 0, rnd128(), rnd128(), rnd128());
        for (int n = 0; n < 6; n++) cyc(1, 0, n[0], rnd128(), rnd128(), rnd128());
        tag = "R7";
        for (int n = 0; n < 20; n++) cyc(1, n[1], n[2], rnd128(), rnd128(), rnd128());
        cyc(1, 0, 0, '0, '0, '0);
        cyc(1, 0, 0, '0, '0, '0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired during %s", tag);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule